// File: doc/BRIEF.md
# Compact-to-Wide Instruction Translation Stage

This block is a single pipeline stage placed between instruction fetch and decode in a core with sixteen registers. With the compatibility mode input set, every 16-bit instruction of a smaller eight-register instruction set is rewritten into the core's native 32-bit encoding. The rewrite widens the register fields. It picks the native form from the source form, moves opcodes and conditions to their native values, and places the immediate field. With the mode input clear, a 16-bit native short instruction passes through zero-extended, and the latency does not change.

The stage takes one instruction per cycle and has exactly one register on the path. A stall input freezes that register so downstream decode can hold off. A source opcode that has no native counterpart raises `out_illegal` and is replaced with the native no-operation word. Program-counter granularity is 16 bits in both modes, so nothing in the address path depends on the mode.

Source layout: bit 15 selects the form (1 = 8-bit immediate, 0 = register form), bits 14:11 hold the opcode, whose upper two bits are the opcode group, and bits 10:8 hold the destination register. In immediate form bits 7:0 hold the immediate. In register form bits 7:5 hold the source register, bits 4:3 are ignored, and bits 2:0 hold the condition. Native layout: bits 31:30 form (00 short, 10 long-immediate, 11 extended), 29:27 group, 26:24 sub-operation, 23:20 destination, 19:16 source, 15:0 tail. The tail carries the 16-bit immediate in long-immediate form and `{cond[3:0], 12'h000}` in extended form. The native no-operation word is `32'h0000_0000`.

Top module: `ctw_xlate_stage`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_illegal` and `out_instr` are cleared to zero.
- R2: With `stall` low, `out_valid` in the cycle after a rising clock edge equals `in_valid` sampled at that edge, so one instruction per cycle leaves with exactly one cycle of latency.
- R3: With mode set, each 3-bit register field becomes 4 bits by copying its bit 2 into bit 3: 0..3 map to 0..3 and 4..7 map to 12..15, so source register 7 always lands on native 15, the program counter.
- R4: With mode set, an immediate-form source (bit 15 = 1) becomes the long-immediate form (bits 31:30 = 10). The 8-bit immediate is sign-extended into bits 15:0 and bits 19:16 are zero.
- R5: With mode set, a register-form source (bit 15 = 0) becomes the extended form (bits 31:30 = 11). The widened source register goes to bits 19:16, the mapped condition to bits 15:12, and bits 11:0 are zero. Source bits 4:3 have no effect.
- R6: Source opcode groups 0, 1, 2, 3 map to native groups 0, 1, 3, 6 in bits 29:27. The sub-operation in bits 26:24 is `{1'b0, opcode[1:0]}`.
- R7: Source conditions 0..7 map to native conditions 0, 2, 3, 4, 5, 6, 7, 1.
- R8: With mode set, source opcodes 14 and 15 (the constant-load pair) in either form set `out_illegal` with `out_valid` and emit `32'h0000_0000`.
- R9: With mode clear, `out_instr` is `{16'h0000, in_instr}` and `out_illegal` stays low.
- R10: While `stall` is high at a clock edge, `out_instr`, `out_valid` and `out_illegal` keep their values, whatever the inputs do.
- R11: With `stall` low and `in_valid` low, `out_valid` and `out_illegal` drop the next cycle and `out_instr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 1 | 1 = translate compact instructions, 0 = pass native through |
| stall | input | 1 | Hold the output register |
| in_valid | input | 1 | Input instruction present |
| in_instr | input | 16 | Fetched instruction |
| out_valid | output | 1 | Output instruction present |
| out_instr | output | 32 | Translated or passed-through instruction |
| out_illegal | output | 1 | Instruction had no native equivalent |

## Verification
Every result of this stage comes from the single output register, so each effect of an input presented before a rising edge is due just after that edge. This holds for the translated word, the trap flag and the valid bit, and for a stall, which must leave all three untouched across that edge. The bench drives inputs on the falling edge, advances its reference model at the rising edge and compares all three outputs on the next falling edge. Each comparison therefore lands exactly one register later than its stimulus, and a stall or bubble is judged in the same cycle as a translation.

// File: rtl/ctw_pkg.sv
// Package: shared widths, field types and encodings for the translation stage.
// Assumes a 16-bit compact source word and a 32-bit native word.
package ctw_pkg;

    localparam int SRC_W      = 16;
    localparam int NAT_W      = 32;
    localparam int SRC_RW     = 3;
    localparam int NAT_RW     = 4;
    localparam int OP_W       = 4;
    localparam int IMM_W      = 8;
    localparam int NAT_IMM_W  = 16;
    localparam int SCND_W     = 3;
    localparam int NCND_W     = 4;
    localparam int GRP_W      = 3;
    localparam int SUB_W      = 3;
    localparam int NREG_FIELD = 2;

    // Native instruction forms
    typedef enum logic [1:0] {
        FORM_SHORT   = 2'b00,
        FORM_LONGIMM = 2'b10,
        FORM_EXT     = 2'b11
    } nat_form_e;

    // Compact source word
    typedef struct packed {
        logic                imm_form;
        logic [OP_W-1:0]     op;
        logic [SRC_RW-1:0]   rd;
        logic [IMM_W-1:0]    low;
    } src_word_t;

    // Native destination word
    typedef struct packed {
        nat_form_e               form;
        logic [GRP_W-1:0]        grp;
        logic [SUB_W-1:0]        sub;
        logic [NAT_RW-1:0]       rd;
        logic [NAT_RW-1:0]       rs;
        logic [NAT_IMM_W-1:0]    tail;
    } nat_word_t;

    localparam logic [NAT_W-1:0] NAT_NOP = '0;

endpackage

// File: rtl/ctw_regmap.sv
// Module: widens a set of compact register fields into native indices.
// Each field copies its top bit into every added bit, so the upper half of
// the compact file lands on the top of the native file. Purely combinational.
module ctw_regmap #(
    parameter int SRC_RW  = ctw_pkg::SRC_RW,
    parameter int NAT_RW  = ctw_pkg::NAT_RW,
    parameter int NFIELDS = ctw_pkg::NREG_FIELD
) (
    input  logic [NFIELDS-1:0][SRC_RW-1:0] src_idx,
    output logic [NFIELDS-1:0][NAT_RW-1:0] nat_idx
);

    localparam int EXT_BITS = NAT_RW - SRC_RW;

    // One widener per register field
    for (genvar g = 0; g < NFIELDS; g++) begin : g_field
        if (EXT_BITS > 0) begin : g_ext
            assign nat_idx[g] = {{EXT_BITS{src_idx[g][SRC_RW-1]}}, src_idx[g]};
        end else begin : g_same
            assign nat_idx[g] = src_idx[g][NAT_RW-1:0];
        end
    end

endmodule

// File: rtl/ctw_opmap.sv
// Module: maps a compact opcode and condition onto native group, sub-operation
// and condition codes, and flags opcodes with no native counterpart.
// Assumes opcode[3:2] is the group and opcode[1:0] the operation inside it.
module ctw_opmap
    import ctw_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [SCND_W-1:0] scond,
    output logic [GRP_W-1:0]  grp,
    output logic [SUB_W-1:0]  sub,
    output logic [NCND_W-1:0] ncond,
    output logic              no_equiv
);

    localparam int GSEL_W = 2;
    localparam int OSEL_W = OP_W - GSEL_W;

    logic [GSEL_W-1:0] gsel;
    logic [OSEL_W-1:0] osel;

    assign gsel = op[OP_W-1 -: GSEL_W];
    assign osel = op[OSEL_W-1:0];

    // Group remap: the four compact groups spread over the native eight
    always_comb begin
        unique case (gsel)
            2'd0:    grp = 3'd0;
            2'd1:    grp = 3'd1;
            2'd2:    grp = 3'd3;
            default: grp = 3'd6;
        endcase
    end

    // Sub-operation: the low opcode bits, zero-padded to native width
    assign sub = {{(SUB_W-OSEL_W){1'b0}}, osel};

    // Condition remap into the native condition table
    always_comb begin
        unique case (scond)
            3'd0:    ncond = 4'd0;
            3'd1:    ncond = 4'd2;
            3'd2:    ncond = 4'd3;
            3'd3:    ncond = 4'd4;
            3'd4:    ncond = 4'd5;
            3'd5:    ncond = 4'd6;
            3'd6:    ncond = 4'd7;
            default: ncond = 4'd1;
        endcase
    end

    // Constant-load low/high have no native equivalent
    always_comb begin
        unique case (op)
            4'd14, 4'd15: no_equiv = 1'b1;
            default:      no_equiv = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctw_assemble.sv
// Module: builds the native word from the mapped fields, or passes the
// source through when translation is off. Combinational; the caller registers it.
module ctw_assemble
    import ctw_pkg::*;
(
    input  logic                 mode,
    input  logic [SRC_W-1:0]     raw,
    input  logic [NAT_RW-1:0]    rd_n,
    input  logic [NAT_RW-1:0]    rs_n,
    input  logic [GRP_W-1:0]     grp,
    input  logic [SUB_W-1:0]     sub,
    input  logic [NCND_W-1:0]    ncond,
    input  logic                 no_equiv,
    output logic [NAT_W-1:0]     word,
    output logic                 trap
);

    localparam int PAD_W  = NAT_IMM_W - IMM_W;
    localparam int TAIL_Z = NAT_IMM_W - NCND_W;

    src_word_t  s;
    nat_word_t  n;

    assign s = src_word_t'(raw);

    // Field placement for the two translated forms
    always_comb begin
        n      = '0;
        n.grp  = grp;
        n.sub  = sub;
        n.rd   = rd_n;
        if (s.imm_form) begin
            n.form = FORM_LONGIMM;
            n.rs   = '0;
            n.tail = {{PAD_W{s.low[IMM_W-1]}}, s.low};
        end else begin
            n.form = FORM_EXT;
            n.rs   = rs_n;
            n.tail = {ncond, {TAIL_Z{1'b0}}};
        end
    end

    // Output selection: pass-through, trap replacement or translation
    always_comb begin
        if (!mode) begin
            word = {{(NAT_W-SRC_W){1'b0}}, raw};
            trap = 1'b0;
        end else if (no_equiv) begin
            word = NAT_NOP;
            trap = 1'b1;
        end else begin
            word = NAT_W'(n);
            trap = 1'b0;
        end
    end

endmodule

// File: rtl/ctw_xlate_stage.sv
// Module: one-cycle fetch-to-decode stage that turns compact 16-bit
// instructions into native 32-bit ones when mode is set. Assumes upstream
// holds its inputs while stall is high; a stall freezes the output register.
module ctw_xlate_stage
    import ctw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              stall,
    input  logic              in_valid,
    input  logic [15:0]       in_instr,
    output logic              out_valid,
    output logic [31:0]       out_instr,
    output logic              out_illegal
);

    src_word_t                              s;
    logic [NREG_FIELD-1:0][SRC_RW-1:0]      reg_src;
    logic [NREG_FIELD-1:0][NAT_RW-1:0]      reg_nat;
    logic [GRP_W-1:0]                       grp;
    logic [SUB_W-1:0]                       sub;
    logic [NCND_W-1:0]                      ncond;
    logic                                   no_equiv;
    logic [NAT_W-1:0]                       word;
    logic                                   trap;

    assign s = src_word_t'(in_instr);

    // Register fields: destination at index 0, source at index 1
    assign reg_src[0] = s.rd;
    assign reg_src[1] = s.low[IMM_W-1 -: SRC_RW];

    ctw_regmap #(
        .SRC_RW  (SRC_RW),
        .NAT_RW  (NAT_RW),
        .NFIELDS (NREG_FIELD)
    ) u_regmap (
        .src_idx (reg_src),
        .nat_idx (reg_nat)
    );

    ctw_opmap u_opmap (
        .op       (s.op),
        .scond    (s.low[SCND_W-1:0]),
        .grp      (grp),
        .sub      (sub),
        .ncond    (ncond),
        .no_equiv (no_equiv)
    );

    ctw_assemble u_asm (
        .mode     (mode),
        .raw      (in_instr),
        .rd_n     (reg_nat[0]),
        .rs_n     (reg_nat[1]),
        .grp      (grp),
        .sub      (sub),
        .ncond    (ncond),
        .no_equiv (no_equiv),
        .word     (word),
        .trap     (trap)
    );

    // Output register: the single pipeline stage, frozen by stall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_instr   <= '0;
        end else if (!stall) begin
            out_valid   <= in_valid;
            out_illegal <= in_valid & trap;
            if (in_valid) begin
                out_instr <= word;
            end
        end
    end

endmodule

// File: rtl/ctw_checker.sv
// Module: temporal checks on the translation stage ports, bound to every
// instance of ctw_xlate_stage. Holds no state of its own.
module ctw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mode,
    input logic        stall,
    input logic        in_valid,
    input logic [15:0] in_instr,
    input logic        out_valid,
    input logic [31:0] out_instr,
    input logic        out_illegal
);

    // R2: one cycle of latency on the valid bit
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> out_valid == $past(in_valid));

    // R10: stall freezes every output
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(out_instr) && $stable(out_valid) && $stable(out_illegal));

    // R8: a trap always carries the no-operation word with valid
    a_r8_trap_nop: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_valid && out_instr == 32'h0000_0000);

    // R9: native pass-through never traps
    a_r9_native_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && in_valid && !mode) |=> !out_illegal);

    // R3: compact register 7 in the destination always lands on the PC
    a_r3_pc_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && in_valid && mode && in_instr[10:8] == 3'd7) |=>
            out_illegal || out_instr[23:20] == 4'hF);

    // R11: a bubble clears valid and trap
    a_r11_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !in_valid) |=> !out_valid && !out_illegal);

endmodule

bind ctw_xlate_stage ctw_checker u_ctw_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .stall       (stall),
    .in_valid    (in_valid),
    .in_instr    (in_instr),
    .out_valid   (out_valid),
    .out_instr   (out_instr),
    .out_illegal (out_illegal)
);

// File: tb/tb_ctw_xlate_stage.sv
// Bench: behavioural reference model stepped once per clock and compared
// against all outputs on every falling edge.
module tb_ctw_xlate_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        stall = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_instr = '0;
    logic        out_valid;
    logic [31:0] out_instr;
    logic        out_illegal;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    logic        m_valid = 1'b0;
    logic [31:0] m_instr = '0;
    logic        m_ill   = 1'b0;

    int gmap [4] = '{0, 1, 3, 6};
    int cmap [8] = '{0, 2, 3, 4, 5, 6, 7, 1};

    always #4 clk = ~clk;

    ctw_xlate_stage dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .stall(stall),
        .in_valid(in_valid), .in_instr(in_instr),
        .out_valid(out_valid), .out_instr(out_instr), .out_illegal(out_illegal)
    );

    function automatic int widen(int r);
        return (r >= 4) ? r + 8 : r;
    endfunction

    function automatic logic [15:0] mk_imm(int op, int rd, int imm);
        return {1'b1, 4'(op), 3'(rd), 8'(imm)};
    endfunction

    function automatic logic [15:0] mk_reg(int op, int rd, int rs, int cnd, int junk);
        return {1'b0, 4'(op), 3'(rd), 3'(rs), 2'(junk), 3'(cnd)};
    endfunction

    // Reference translation, written from the requirements
    function automatic void ref_xlate(input logic [15:0] w, input logic md,
                                      output logic [31:0] res, output logic ill);
        int op, rd, g, sb;
        logic [31:0] r;
        op = int'(w[14:11]);
        rd = widen(int'(w[10:8]));
        ill = 1'b0;
        if (!md) begin
            res = {16'h0, w};
            return;
        end
        if (op >= 14) begin
            res = 32'h0;
            ill = 1'b1;
            return;
        end
        g  = gmap[op / 4];
        sb = op % 4;
        r  = (32'(g) << 27) | (32'(sb) << 24) | (32'(rd) << 20);
        if (w[15]) begin
            r = r | (32'd2 << 30);
            if (w[7]) r = r | 32'h0000_FF00;
            r = r | 32'(w[7:0]);
        end else begin
            r = r | (32'd3 << 30);
            r = r | (32'(widen(int'(w[7:5]))) << 16);
            r = r | (32'(cmap[int'(w[2:0])]) << 12);
        end
        res = r;
    endfunction

    task automatic compare(string tag);
        vectors++;
        if (out_valid !== m_valid || out_instr !== m_instr || out_illegal !== m_ill) begin
            misses++;
            $display("FAIL %s: got valid=%0b instr=%08h illegal=%0b, expected valid=%0b instr=%08h illegal=%0b",
                     tag, out_valid, out_instr, out_illegal, m_valid, m_instr, m_ill);
        end
    endtask

    // One clock: drive at negedge, advance model at posedge, compare at next negedge
    task automatic step(input logic v, input logic [15:0] w, input logic md,
                        input logic st, input string tag);
        logic [31:0] e;
        logic        il;
        in_valid = v; in_instr = w; mode = md; stall = st;
        @(posedge clk);
        if (!st) begin
            m_valid = v;
            if (v) begin
                ref_xlate(w, md, e, il);
                m_instr = e;
                m_ill   = il;
            end else begin
                m_ill = 1'b0;
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            misses++;
            vectors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with live inputs present
        @(negedge clk);
        in_valid = 1'b1; in_instr = 16'hFFFF; mode = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;

        // R3: every destination and source register
        for (int r = 0; r < 8; r++) begin
            step(1, mk_imm(0, r, 5), 1, 0, "R3 rd");
            step(1, mk_reg(1, r, 7 - r, 0, 0), 1, 0, "R3 rd/rs");
        end

        // R4: immediates including sign boundaries
        step(1, mk_imm(2, 1, 8'h00), 1, 0, "R4 imm zero");
        step(1, mk_imm(2, 1, 8'h7F), 1, 0, "R4 imm max pos");
        step(1, mk_imm(2, 1, 8'h80), 1, 0, "R4 imm min neg");
        step(1, mk_imm(2, 1, 8'hFF), 1, 0, "R4 imm -1");

        // R6: every legal opcode in both forms
        for (int op = 0; op < 14; op++) begin
            step(1, mk_imm(op, 3, op * 17), 1, 0, "R6 imm group");
            step(1, mk_reg(op, 4, 2, 1, 0), 1, 0, "R6 reg group");
        end

        // R7 and R5: every condition, with the ignored bits varied
        for (int c = 0; c < 8; c++) begin
            step(1, mk_reg(5, 6, 3, c, 0), 1, 0, "R7 cond");
            step(1, mk_reg(5, 6, 3, c, 3), 1, 0, "R5 ignored bits");
        end

        // R8: constant-load pair in both forms
        step(1, mk_imm(14, 2, 8'h55), 1, 0, "R8 imm op14");
        step(1, mk_imm(15, 7, 8'hAA), 1, 0, "R8 imm op15");
        step(1, mk_reg(14, 0, 0, 0, 0), 1, 0, "R8 reg op14");
        step(1, mk_reg(15, 7, 7, 7, 0), 1, 0, "R8 reg op15");

        // R9: pass-through, including words that would trap when translated
        step(1, 16'hF000, 0, 0, "R9 native");
        step(1, 16'h1234, 0, 0, "R9 native");
        step(1, 16'h8001, 0, 0, "R9 native");

        // R10: stall holds a trap and a normal word against changing inputs
        step(1, mk_imm(15, 1, 1), 1, 0, "R10 setup");
        step(1, mk_imm(1, 1, 1), 1, 1, "R10 hold trap");
        step(0, 16'h0000, 0, 1, "R10 hold trap");
        step(1, mk_reg(2, 5, 5, 2, 0), 1, 0, "R10 setup");
        step(1, mk_imm(3, 0, 9), 1, 1, "R10 hold word");
        step(1, 16'hFFFF, 0, 1, "R10 hold word");

        // R11: bubbles after a trap and after a word, then recovery
        step(1, mk_imm(14, 0, 0), 1, 0, "R11 setup");
        step(0, mk_imm(1, 1, 1), 1, 0, "R11 bubble");
        step(1, mk_imm(1, 2, 3), 1, 0, "R11 setup");
        step(0, 16'hABCD, 0, 0, "R11 bubble");

        // R2: back-to-back with mode toggling every cycle
        for (int i = 0; i < 16; i++)
            step(1, mk_reg(i % 14, i % 8, (i + 3) % 8, i % 8, 0), (i % 2 == 0), 0, "R2 stream");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule